// File: doc/BRIEF.md
# Split Read/Write Memory Bank Mapper

This block sits between a CPU's 16-bit address bus and a paged RAM of up to 512 KB. The 64 KB CPU space is cut into four 16 KB windows. Each window has a configuration byte, and software writes these bytes through four consecutive I/O ports. One extra port holds a shared force byte. From these bytes the mapper derives two banks per window, one for reads and one for writes. Each access is then turned into a 19-bit physical RAM address.

The mapper also steers two overlays away from RAM. A read from the last sixteen bytes of any window whose read bank is 3 selects a keyboard-matrix byte instead of RAM. While the boot flag is still set, reads in the lowest window come from a boot ROM. The flag is set by reset and cleared by a boot-end pulse.

The translation is combinational from registered configuration. A register write changes the mapping from the next clock cycle. The installed RAM size is a build parameter.

Top module: `bankmap_top`

## Requirements
- R1: After reset the four window bytes hold 0, 1, 2 and 3 (window n holds n), the force byte holds 0 and the boot flag is set. So writes to window n use bank n, and reads in windows 1 to 3 use bank 0.
- R2: An I/O write to port PORT_BASE+n (n = 0..3) loads the window-n byte with the write data. The new mapping applies from the next cycle on.
- R3: When bit 7 of a window byte is 1, bits 6:0 give a single bank that is used for both reads and writes in that window.
- R4: When bit 7 of a window byte is 0, the write bank is bits 2:0 and the read bank is bits 6:4.
- R5: An I/O write to FORCE_PORT loads the force byte. From the next cycle its bits 6, 4, 5 and 7 apply to windows 0, 1, 2 and 3 respectively. When a window's force bit is 1 and its bit 7 is 0, its read bank becomes bits 2:0. This change affects all four windows at once.
- R6: phys_addr = (bank mod (RAM_KB/16)) * 16384 + cpu_addr[13:0]. The bank is the write bank when cpu_wr is 1, and the read bank otherwise.
- R7: A read (cpu_rd=1, cpu_wr=0) whose unreduced 7-bit read bank equals 3, at window offset 3FF0h to 3FFFh, drives kbd_sel=1 and kbd_index=cpu_addr[3:0], with ram_sel=0. kbd_index is 0 whenever kbd_sel is 0. A write to those offsets goes to RAM.
- R8: While the boot flag is set, any read in window 0 drives rom_sel=1 and ram_sel=0. This takes priority over the keyboard overlay. Writes to window 0 still go to RAM. A boot_end pulse clears the flag from the next cycle on, and the flag stays clear until reset.
- R9: Reset has priority over everything: with rst_n low, all four bytes, the force byte and the boot flag return to their R1 values.
- R10: ram_sel, kbd_sel and rom_sel are never active together. All three are 0 when neither cpu_rd nor cpu_wr is active. If both strobes are active, the access is treated as a write.
- R11: An I/O write to any port other than PORT_BASE..PORT_BASE+3 and FORCE_PORT changes no window byte and no force bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU memory address |
| cpu_rd | input | 1 | CPU memory read strobe |
| cpu_wr | input | 1 | CPU memory write strobe |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 8 | I/O port number |
| io_wdata | input | 8 | I/O write data |
| boot_end | input | 1 | One-cycle pulse that ends the boot overlay |
| phys_addr | output | 19 | Physical RAM address |
| ram_sel | output | 1 | Access goes to RAM |
| kbd_sel | output | 1 | Read goes to the keyboard matrix |
| kbd_index | output | 4 | Keyboard matrix byte index |
| rom_sel | output | 1 | Read goes to the boot ROM |

## Verification
The bench builds the mapper with RAM_KB=256, which means only 16 banks are installed. Any bank value of 16 or above must therefore wrap. This setting tests the reduction against the keyboard check: bank 19 lands on RAM bank 3 but must not open the keyboard overlay. The default port numbers F0h–F3h and F4h are kept. Random I/O traffic to the neighbouring ports F5h–F8h and 80h exercises the ignore rule.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;
  localparam int unsigned WIN_COUNT = 4;
  localparam int unsigned WIN_OFF_W = 14;
  localparam int unsigned BANK_W    = 7;
  localparam int unsigned PHYS_W    = 19;

  typedef logic [7:0]        winreg_t;
  typedef logic [BANK_W-1:0] bank_t;

  // Which bit of the force byte belongs to each window (order is fixed by behaviour).
  function automatic int unsigned force_pos(int unsigned win);
    case (win)
      0:       return 6;
      1:       return 4;
      2:       return 5;
      default: return 7;
    endcase
  endfunction

  function automatic bank_t rd_bank_of(winreg_t cfg, logic frc);
    if (cfg[7]) return cfg[6:0];
    if (frc)    return {4'b0000, cfg[2:0]};
    return {4'b0000, cfg[6:4]};
  endfunction

  function automatic bank_t wr_bank_of(winreg_t cfg);
    if (cfg[7]) return cfg[6:0];
    return {4'b0000, cfg[2:0]};
  endfunction

  function automatic logic [PHYS_W-1:0] phys_of(bank_t b, bank_t mask,
                                                logic [WIN_OFF_W-1:0] off);
    logic [PHYS_W-1:0] hi;
    hi = PHYS_W'(b & mask) << WIN_OFF_W;
    return hi | PHYS_W'(off);
  endfunction

  function automatic logic in_kbd_slot(logic [WIN_OFF_W-1:0] off);
    return &off[WIN_OFF_W-1:4];
  endfunction
endpackage

// File: rtl/bankmap_regs.sv
module bankmap_regs
  import bankmap_pkg::*;
#(
  parameter int unsigned PORT_BASE  = 8'hF0,
  parameter int unsigned FORCE_PORT = 8'hF4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          io_wr,
  input  logic [7:0]                    io_addr,
  input  logic [7:0]                    io_wdata,
  input  logic                          boot_end,
  output logic [WIN_COUNT-1:0][7:0]     win_q,
  output logic [7:0]                    force_q,
  output logic                          boot_q
);
  logic [WIN_COUNT-1:0] win_hit;
  logic                 force_hit;
  logic                 any_hit;

  for (genvar w = 0; w < WIN_COUNT; w++) begin : g_win
    logic [7:0] cfg_q;
    assign win_hit[w] = io_wr && (io_addr == 8'(PORT_BASE + w));
    always_ff @(posedge clk) begin
      if (!rst_n)          cfg_q <= 8'(w);
      else if (win_hit[w]) cfg_q <= io_wdata;
    end
    assign win_q[w] = cfg_q;

    AST_WIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      win_hit[w] |=> (cfg_q == $past(io_wdata))) else $error("window load"); // R2
  end

  assign force_hit = io_wr && (io_addr == 8'(FORCE_PORT));
  assign any_hit   = force_hit || (|win_hit);

  always_ff @(posedge clk) begin
    if (!rst_n)         force_q <= 8'h00;
    else if (force_hit) force_q <= io_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        boot_q <= 1'b1;
    else if (boot_end) boot_q <= 1'b0;
  end

  AST_BOOT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_q |=> !boot_q) else $error("boot flag"); // R8
  AST_FOREIGN_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !any_hit) |=> ($stable(win_q) && $stable(force_q))) else $error("foreign port"); // R11
  AST_FORCE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    force_hit |=> (force_q == $past(io_wdata))) else $error("force load"); // R5
endmodule

// File: rtl/bankmap_win.sv
module bankmap_win
  import bankmap_pkg::*;
#(
  parameter int unsigned WIN_IDX = 0
) (
  input  logic [7:0] cfg,
  input  logic [7:0] force_q,
  output bank_t      rd_bank,
  output bank_t      wr_bank
);
  localparam int unsigned FBIT = force_pos(WIN_IDX);

  logic frc;
  assign frc     = force_q[FBIT];
  assign rd_bank = rd_bank_of(cfg, frc);
  assign wr_bank = wr_bank_of(cfg);
endmodule

// File: rtl/bankmap_xlate.sv
module bankmap_xlate
  import bankmap_pkg::*;
#(
  parameter int unsigned RAM_KB = 512
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [15:0]                   cpu_addr,
  input  logic                          cpu_rd,
  input  logic                          cpu_wr,
  input  logic                          boot_q,
  input  logic [WIN_COUNT-1:0][BANK_W-1:0] rd_banks,
  input  logic [WIN_COUNT-1:0][BANK_W-1:0] wr_banks,
  output logic [PHYS_W-1:0]             phys_addr,
  output logic                          ram_sel,
  output logic                          kbd_sel,
  output logic [3:0]                    kbd_index,
  output logic                          rom_sel
);
  localparam int unsigned RAM_BANKS = RAM_KB / 16;
  localparam int unsigned RAM_BYTES = RAM_KB * 1024;
  localparam bank_t       BANK_MASK = BANK_W'(RAM_BANKS - 1);

  logic [1:0]           win_idx;
  logic [WIN_OFF_W-1:0] win_off;
  logic                 is_write;
  logic                 is_read;
  bank_t                cur_rd_bank;
  bank_t                cur_wr_bank;
  bank_t                use_bank;
  logic                 rom_hit;
  logic                 kbd_hit;

  assign win_idx     = cpu_addr[15:14];
  assign win_off     = cpu_addr[WIN_OFF_W-1:0];
  assign is_write    = cpu_wr;
  assign is_read     = cpu_rd && !cpu_wr;
  assign cur_rd_bank = rd_banks[win_idx];
  assign cur_wr_bank = wr_banks[win_idx];
  assign use_bank    = is_write ? cur_wr_bank : cur_rd_bank;

  assign rom_hit = is_read && boot_q && (win_idx == 2'd0);
  assign kbd_hit = is_read && !rom_hit && (cur_rd_bank == bank_t'(3)) && in_kbd_slot(win_off);

  assign phys_addr = phys_of(use_bank, BANK_MASK, win_off);
  assign rom_sel   = rom_hit;
  assign kbd_sel   = kbd_hit;
  assign kbd_index = kbd_hit ? cpu_addr[3:0] : 4'h0;
  assign ram_sel   = (is_write || is_read) && !rom_hit && !kbd_hit;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_sel, kbd_sel, rom_sel})) else $error("selects"); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_rd || cpu_wr) |-> !(ram_sel || kbd_sel || rom_sel)) else $error("idle"); // R10
  AST_KBD_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_sel |-> (cpu_rd && !cpu_wr && (cpu_addr[13:4] == 10'h3FF))) else $error("kbd"); // R7
  AST_ROM_WIN0: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> (boot_q && cpu_addr[15:14] == 2'd0 && !cpu_wr)) else $error("rom"); // R8
  AST_PHYS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(phys_addr) < RAM_BYTES) else $error("phys range"); // R6
endmodule

// File: rtl/bankmap_top.sv
module bankmap_top
  import bankmap_pkg::*;
#(
  parameter int unsigned RAM_KB     = 512,
  parameter int unsigned PORT_BASE  = 8'hF0,
  parameter int unsigned FORCE_PORT = 8'hF4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  input  logic        io_wr,
  input  logic [7:0]  io_addr,
  input  logic [7:0]  io_wdata,
  input  logic        boot_end,
  output logic [18:0] phys_addr,
  output logic        ram_sel,
  output logic        kbd_sel,
  output logic [3:0]  kbd_index,
  output logic        rom_sel
);
  logic [WIN_COUNT-1:0][7:0]        win_q;
  logic [7:0]                       force_q;
  logic                             boot_q;
  logic [WIN_COUNT-1:0][BANK_W-1:0] rd_banks;
  logic [WIN_COUNT-1:0][BANK_W-1:0] wr_banks;

  bankmap_regs #(.PORT_BASE(PORT_BASE), .FORCE_PORT(FORCE_PORT)) u_regs (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .boot_end(boot_end),
    .win_q(win_q), .force_q(force_q), .boot_q(boot_q)
  );

  for (genvar w = 0; w < WIN_COUNT; w++) begin : g_dec
    bankmap_win #(.WIN_IDX(w)) u_win (
      .cfg(win_q[w]), .force_q(force_q),
      .rd_bank(rd_banks[w]), .wr_bank(wr_banks[w])
    );
  end

  bankmap_xlate #(.RAM_KB(RAM_KB)) u_xlate (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .boot_q(boot_q), .rd_banks(rd_banks), .wr_banks(wr_banks),
    .phys_addr(phys_addr), .ram_sel(ram_sel), .kbd_sel(kbd_sel),
    .kbd_index(kbd_index), .rom_sel(rom_sel)
  );
endmodule

// File: tb/sim_bankmap_top.sv
module sim_bankmap_top;
  localparam int RAM_KB = 256;
  localparam int NBANKS = RAM_KB / 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0, io_wr = 1'b0, boot_end = 1'b0;
  logic [7:0]  io_addr = '0, io_wdata = '0;
  logic [18:0] phys_addr;
  logic        ram_sel, kbd_sel, rom_sel;
  logic [3:0]  kbd_index;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  // reference state
  int winr [4];
  int forcer;
  bit bootr;
  int fmap [4] = '{6, 4, 5, 7};

  always #2.5 clk = ~clk;

  bankmap_top #(.RAM_KB(RAM_KB)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata), .boot_end(boot_end),
    .phys_addr(phys_addr), .ram_sel(ram_sel), .kbd_sel(kbd_sel),
    .kbd_index(kbd_index), .rom_sel(rom_sel)
  );

  function automatic int rbank(int w);
    int r = winr[w];
    if (r >= 128) return r - 128;
    if (((forcer >> fmap[w]) & 1) == 1) return r % 8;
    return (r / 16) % 8;
  endfunction

  function automatic int wbank(int w);
    int r = winr[w];
    return (r >= 128) ? r - 128 : r % 8;
  endfunction

  task automatic model_reset();
    for (int w = 0; w < 4; w++) winr[w] = w;
    forcer = 0;
    bootr  = 1'b1;
  endtask

  task automatic report(string tag, string what, int act, int exp);
    $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
  endtask

  task automatic step(string tag, logic [15:0] a, logic rd, logic wr,
                      logic iow, logic [7:0] ia, logic [7:0] id, logic be);
    int  w, off, bank, e_phys, e_idx;
    bit  rdo, e_rom, e_kbd, e_ram, bad;
    @(negedge clk);
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr;
    io_wr = iow; io_addr = ia; io_wdata = id; boot_end = be;
    #1;
    w   = int'(a[15:14]);
    off = int'(a[13:0]);
    rdo = rd && !wr;
    e_rom = rdo && bootr && (w == 0);
    e_kbd = rdo && !e_rom && (rbank(w) == 3) && (off >= 'h3FF0);
    e_ram = (rd || wr) && !e_rom && !e_kbd;
    bank  = wr ? wbank(w) : rbank(w);
    e_phys = (bank % NBANKS) * 16384 + off;
    e_idx  = e_kbd ? off % 16 : 0;
    bad = 1'b0;
    if (int'(phys_addr) != e_phys) begin report(tag == "" ? "R6" : tag, "phys_addr", int'(phys_addr), e_phys); bad = 1'b1; end
    if (kbd_sel != e_kbd)          begin report(tag == "" ? "R7" : tag, "kbd_sel", int'(kbd_sel), int'(e_kbd)); bad = 1'b1; end
    if (int'(kbd_index) != e_idx)  begin report(tag == "" ? "R7" : tag, "kbd_index", int'(kbd_index), e_idx); bad = 1'b1; end
    if (rom_sel != e_rom)          begin report(tag == "" ? "R8" : tag, "rom_sel", int'(rom_sel), int'(e_rom)); bad = 1'b1; end
    if (ram_sel != e_ram)          begin report(tag == "" ? "R10" : tag, "ram_sel", int'(ram_sel), int'(e_ram)); bad = 1'b1; end
    vectors++;
    if (bad) misses++;
    // state after the coming edge
    if (iow && ia >= 8'hF0 && ia <= 8'hF3) winr[int'(ia) - 'hF0] = int'(id);
    if (iow && ia == 8'hF4) forcer = int'(id);
    if (be) bootr = 1'b0;
  endtask

  task automatic rd_at(string tag, logic [15:0] a); step(tag, a, 1, 0, 0, 0, 0, 0); endtask
  task automatic wr_at(string tag, logic [15:0] a); step(tag, a, 0, 1, 0, 0, 0, 0); endtask
  task automatic io_put(string tag, logic [7:0] p, logic [7:0] d); step(tag, 16'h0000, 0, 0, 1, p, d, 0); endtask

  initial begin : watchdog
    #(5 * 150000);
    if (!done) begin
      $display("FAIL watchdog expired: actual hung expected finish");
      misses++;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin : main
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset mapping
    wr_at("R1", 16'h4005); wr_at("R1", 16'hC123);
    rd_at("R1", 16'h8123); rd_at("R1", 16'h4FFF); rd_at("R1", 16'h0010);
    // R2 / R4: split bank, visible next cycle
    io_put("R2", 8'hF1, 8'h52);
    rd_at("R4", 16'h4100); wr_at("R4", 16'h4100);
    // R3: single bank
    io_put("R3", 8'hF2, 8'h8B);
    rd_at("R3", 16'h8001); wr_at("R3", 16'hBFFF);
    // R5: force bits, per-window mapping and all-at-once
    io_put("R5", 8'hF4, 8'h10);
    rd_at("R5", 16'h4100); rd_at("R5", 16'hC000);
    io_put("R5", 8'hF3, 8'h61);
    rd_at("R5", 16'hC010);
    io_put("R5", 8'hF4, 8'hF0);
    rd_at("R5", 16'hC010); rd_at("R5", 16'h4010);
    // R6: bank above installed size wraps, no keyboard for raw 19
    io_put("R6", 8'hF3, 8'h93);
    rd_at("R6", 16'hFFF5); wr_at("R6", 16'hC000);
    // R7: keyboard overlay edges
    io_put("R7", 8'hF3, 8'h83);
    rd_at("R7", 16'hFFF0); rd_at("R7", 16'hFFFF); rd_at("R7", 16'hFFEF); wr_at("R7", 16'hFFF8);
    // R8: boot ROM beats keyboard in window 0, writes still to RAM, boot_end
    io_put("R8", 8'hF0, 8'h83);
    rd_at("R8", 16'h3FF4); wr_at("R8", 16'h0000);
    step("R8", 16'h0000, 0, 0, 0, 0, 0, 1);
    rd_at("R8", 16'h3FF4); rd_at("R8", 16'h0100);
    // R10: idle and both strobes
    step("R10", 16'hFFF3, 0, 0, 0, 0, 0, 0);
    step("R10", 16'hFFF3, 1, 1, 0, 0, 0, 0);
    // R11: foreign ports leave mapping alone
    io_put("R11", 8'hF5, 8'h00); io_put("R11", 8'hF8, 8'h00); io_put("R11", 8'hEF, 8'h00);
    rd_at("R11", 16'hFFF1); rd_at("R11", 16'h4100);

    // R9: reset mid-run restores everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    model_reset();
    rd_at("R9", 16'h0000); rd_at("R9", 16'hFFF2); wr_at("R9", 16'h8004);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      logic [7:0]  p, d;
      int k;
      k = $urandom_range(0, 7);
      p = (k < 5) ? 8'(8'hF0 + k) : ((k == 5) ? 8'(8'hF5 + $urandom_range(0, 3)) : 8'h80);
      d = 8'($urandom);
      if ($urandom_range(0, 2) == 0) d = {d[7], 3'd3, d[3], 3'($urandom_range(2, 3))};
      a = 16'($urandom);
      if ($urandom_range(0, 1) == 0) a[13:4] = 10'h3FF;
      step("", a, 1'($urandom), 1'($urandom_range(0, 3) == 0),
           1'($urandom_range(0, 3) == 0), p, d, (i > 2000) && ($urandom_range(0, 300) == 0));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule